// File: doc/BRIEF.md
# Receive Queue with Per-Character Line Status

This block is the receive-side character queue of a serial port. Each character handed over by the deserializer is stored together with three error flags: break, framing error and parity error. The host read path takes characters from the head of the queue one at a time. The flags that travel with the head character are presented as the live line-status error bits for that character.

Next to the per-character view, the block keeps a summary flag. The summary is set while at least one stored character carries any error, and it stays set until the last such character has been read out. This summary is the source of the receiver-line-status interrupt.

A fill level, empty and full flags, a one-cycle overrun pulse for a rejected push, and a synchronous queue clear complete the interface.

Top module: `rx_err_fifo`

## Requirements
- R1: The queue holds up to DEPTH (default 64) characters. `level` equals the number stored, `empty` is high exactly when `level` is 0, and `full` is high exactly when `level` equals DEPTH.
- R2: Characters leave through `head_data` in the order they were pushed.
- R3: While the queue is not empty, `head_brk`, `head_fe` and `head_pe` equal the break, framing and parity flags pushed with the character shown on `head_data`.
- R4: In the cycle after an accepted pop, the head outputs already show the data and flags of the next stored character, with no extra latency.
- R5: While the queue is empty, `head_data` and all three head flags read as zero.
- R6: `err_any` is high while any stored character has any of its three flags set. It is low when no such character remains, including when the queue is empty.
- R7: A push and a pop in the same cycle both take effect when the queue is not empty, and the level stays unchanged. With a full queue, a push together with a pop is accepted.
- R8: A push to a full queue with no pop in the same cycle is discarded, and `overrun` is high for exactly the one cycle that follows it.
- R9: A pop while the queue is empty has no effect. The level stays 0 and `err_any` stays low.
- R10: A high `clr` at a clock edge empties the queue and clears `err_any`. Any push or pop in that same cycle is discarded, and no overrun is raised.
- R11: While reset is held, and after it is released, the queue is empty, `err_any` is low and `overrun` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| clr | input | 1 | Synchronous queue clear |
| push | input | 1 | Push strobe from the receiver |
| push_data | input | 8 | Character to store |
| push_brk | input | 1 | Break flag of the pushed character |
| push_fe | input | 1 | Framing-error flag of the pushed character |
| push_pe | input | 1 | Parity-error flag of the pushed character |
| pop | input | 1 | Pop strobe from the host read path |
| head_data | output | 8 | Character at the head, or zero when empty |
| head_brk | output | 1 | Break flag of the head character |
| head_fe | output | 1 | Framing flag of the head character |
| head_pe | output | 1 | Parity flag of the head character |
| err_any | output | 1 | High while any stored character has an error |
| level | output | 7 | Number of stored characters |
| empty | output | 1 | Queue empty |
| full | output | 1 | Queue full |
| overrun | output | 1 | One-cycle pulse after a discarded push |

## Verification
The checker covers the following on every cycle:
- zero head outputs on an empty queue;
- a set head flag always implying the summary;
- the empty, full and level consistency;
- the cause of every overrun pulse;
- the effect of clear, of a pop on an empty queue, and of a simultaneous push and pop.

Other behaviour can only be seen across sequences of stimulus, so the bench scenarios show it:
- the order in which characters leave;
- that each flag stays attached to its own character through wrap-around;
- that the summary clears only when the last erroneous character is popped, even with clean characters around it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  localparam int RXQ_DATA_W = 8;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rxq_flags_t;

  typedef struct packed {
    rxq_flags_t             flg;
    logic [RXQ_DATA_W-1:0]  data;
  } rxq_entry_t;

endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[STAGES-1];

endmodule

// File: rtl/rxq_ptr_ctrl.sv
module rxq_ptr_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  output logic          wr_en,
  output logic          rd_en,
  output logic [AW-1:0] wr_ptr,
  output logic [AW-1:0] rd_ptr,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          overrun
);

  localparam logic [LW-1:0] LVL_MAX  = LW'(DEPTH);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [AW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [LW-1:0] level_q, level_d;
  logic          ovr_q, ovr_d;
  logic          rd_ok, wr_ok;

  assign empty = (level_q == '0);
  assign full  = (level_q == LVL_MAX);

  always_comb begin
    rd_ok = pop && !empty;
    wr_ok = push && (!full || rd_ok);
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    level_d  = level_q;
    ovr_d    = 1'b0;
    if (clr) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      level_d  = '0;
    end else begin
      ovr_d = push && !wr_ok;
      if (wr_ok) begin
        wr_ptr_d = (wr_ptr_q == PTR_LAST) ? '0 : wr_ptr_q + 1'b1;
      end
      if (rd_ok) begin
        rd_ptr_d = (rd_ptr_q == PTR_LAST) ? '0 : rd_ptr_q + 1'b1;
      end
      case ({wr_ok, rd_ok})
        2'b10:   level_d = level_q + 1'b1;
        2'b01:   level_d = level_q - 1'b1;
        default: level_d = level_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level_q  <= '0;
      ovr_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      level_q  <= level_d;
      ovr_q    <= ovr_d;
    end
  end

  assign wr_en   = wr_ok && !clr;
  assign rd_en   = rd_ok && !clr;
  assign wr_ptr  = wr_ptr_q;
  assign rd_ptr  = rd_ptr_q;
  assign level   = level_q;
  assign overrun = ovr_q;

endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_ptr,
  input  rxq_entry_t    wr_entry,
  input  logic [AW-1:0] rd_ptr,
  output rxq_entry_t    rd_entry
);

  rxq_entry_t mem [DEPTH];

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (wr_ptr == AW'(gi));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        mem[gi] <= wr_entry;
      end
    end
  end

  assign rd_entry = mem[rd_ptr];

endmodule

// File: rtl/rxq_err_track.sv
module rxq_err_track #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push_ok,
  input  logic          push_err,
  input  logic          pop_ok,
  input  logic          pop_err,
  output logic [LW-1:0] err_cnt,
  output logic          err_any
);

  logic [LW-1:0] cnt_q, cnt_d;
  logic          inc, dec;

  always_comb begin
    inc   = push_ok && push_err;
    dec   = pop_ok && pop_err;
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else begin
      case ({inc, dec})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign err_cnt = cnt_q;
  assign err_any = (cnt_q != '0);

endmodule

// File: rtl/rx_err_fifo.sv
module rx_err_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  push,
  input  logic [RXQ_DATA_W-1:0] push_data,
  input  logic                  push_brk,
  input  logic                  push_fe,
  input  logic                  push_pe,
  input  logic                  pop,
  output logic [RXQ_DATA_W-1:0] head_data,
  output logic                  head_brk,
  output logic                  head_fe,
  output logic                  head_pe,
  output logic                  err_any,
  output logic [LW-1:0]         level,
  output logic                  empty,
  output logic                  full,
  output logic                  overrun
);

  logic          rst_n_i;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] err_cnt;
  rxq_entry_t    wr_entry, rd_entry;
  logic          push_err, head_err;

  rxq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  always_comb begin
    wr_entry.data    = push_data;
    wr_entry.flg.brk = push_brk;
    wr_entry.flg.fe  = push_fe;
    wr_entry.flg.pe  = push_pe;
    push_err         = push_brk || push_fe || push_pe;
  end

  rxq_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .clr     (clr),
    .push    (push),
    .pop     (pop),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_ptr  (wr_ptr),
    .rd_ptr  (rd_ptr),
    .level   (level),
    .empty   (empty),
    .full    (full),
    .overrun (overrun)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk      (clk),
    .wr_en    (wr_en),
    .wr_ptr   (wr_ptr),
    .wr_entry (wr_entry),
    .rd_ptr   (rd_ptr),
    .rd_entry (rd_entry)
  );

  assign head_err = rd_entry.flg.brk || rd_entry.flg.fe || rd_entry.flg.pe;

  rxq_err_track #(.DEPTH(DEPTH)) u_err (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .clr      (clr),
    .push_ok  (wr_en),
    .push_err (push_err),
    .pop_ok   (rd_en),
    .pop_err  (head_err),
    .err_cnt  (err_cnt),
    .err_any  (err_any)
  );

  always_comb begin
    if (empty) begin
      head_data = '0;
      head_brk  = 1'b0;
      head_fe   = 1'b0;
      head_pe   = 1'b0;
    end else begin
      head_data = rd_entry.data;
      head_brk  = rd_entry.flg.brk;
      head_fe   = rd_entry.flg.fe;
      head_pe   = rd_entry.flg.pe;
    end
  end

endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int DEPTH = 64,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr,
  input logic          push,
  input logic          pop,
  input logic [7:0]    head_data,
  input logic          head_brk,
  input logic          head_fe,
  input logic          head_pe,
  input logic          err_any,
  input logic [LW-1:0] level,
  input logic          empty,
  input logic          full,
  input logic          overrun
);

  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (level <= LVL_MAX) && !(full && empty));

  assert_empty_head_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (head_data == 8'h00 && !head_brk && !head_fe && !head_pe));

  assert_head_err_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (head_brk || head_fe || head_pe) |-> err_any);

  assert_empty_no_summary_R6: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !err_any);

  assert_pushpop_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !clr) |=> $stable(level));

  assert_overrun_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(push && full && !pop && !clr));

  assert_pop_empty_noop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push && empty && !clr) |=> (empty && !err_any));

  assert_clear_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty && !err_any && !overrun));

endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .clr       (clr),
  .push      (push),
  .pop       (pop),
  .head_data (head_data),
  .head_brk  (head_brk),
  .head_fe   (head_fe),
  .head_pe   (head_pe),
  .err_any   (err_any),
  .level     (level),
  .empty     (empty),
  .full      (full),
  .overrun   (overrun)
);

// File: tb/rx_err_fifo_tb.sv
`timescale 1ns/1ps
module rx_err_fifo_tb;

  localparam int DEPTH = 64;

  logic       clk;
  logic       rst_n;
  logic       clr, push, pop;
  logic [7:0] push_data;
  logic       push_brk, push_fe, push_pe;
  logic [7:0] head_data;
  logic       head_brk, head_fe, head_pe;
  logic       err_any, empty, full, overrun;
  logic [6:0] level;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [10:0] q[$];
  logic        exp_ovr = 0;
  logic [15:0] lfsr = 16'hACE1;

  rx_err_fifo #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .push(push), .push_data(push_data),
    .push_brk(push_brk), .push_fe(push_fe), .push_pe(push_pe), .pop(pop),
    .head_data(head_data), .head_brk(head_brk), .head_fe(head_fe), .head_pe(head_pe),
    .err_any(err_any), .level(level), .empty(empty), .full(full), .overrun(overrun)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit model_err();
    foreach (q[i]) if (q[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  task automatic compare();
    logic [10:0] h;
    h = (q.size() > 0) ? q[0] : 11'h0;
    chk(level == 7'(q.size()), "R1 level", level, q.size());
    chk(empty == (q.size() == 0) && full == (q.size() == DEPTH), "R1 empty/full",
        {empty, full}, {(q.size() == 0), (q.size() == DEPTH)});
    chk(head_data == h[7:0], "R2 head_data", head_data, h[7:0]);
    chk({head_brk, head_fe, head_pe} == h[10:8], "R3 head flags",
        {head_brk, head_fe, head_pe}, h[10:8]);
    chk(err_any == model_err(), "R6 err_any", err_any, model_err());
    chk(overrun == exp_ovr, "R8 overrun", overrun, exp_ovr);
  endtask

  // flags order {brk,fe,pe}
  task automatic step(input bit pu, input logic [7:0] d, input logic [2:0] f,
                      input bit po, input bit cl);
    bit do_pop, do_push;
    push = pu; push_data = d; {push_brk, push_fe, push_pe} = f; pop = po; clr = cl;
    @(posedge clk);
    if (cl) begin
      q.delete();
      exp_ovr = 0;
    end else begin
      do_pop  = po && (q.size() > 0);
      do_push = pu && (q.size() < DEPTH || do_pop);
      exp_ovr = pu && !do_push;
      if (do_pop) void'(q.pop_front());
      if (do_push) q.push_back({f, d});
    end
    @(negedge clk);
    push = 0; pop = 0; clr = 0;
    compare();
  endtask

  task automatic idle(); step(0, 8'h00, 3'b000, 0, 0); endtask

  initial begin
    #1500000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; clr = 0; push = 0; pop = 0; push_data = 0;
    push_brk = 0; push_fe = 0; push_pe = 0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(empty && level == 0 && !err_any && !overrun, "R11 reset state",
        {empty, err_any, overrun}, 3'b100);
    rst_n = 1;
    repeat (3) idle();
    chk(empty && !err_any && !overrun, "R11 after release", {empty, err_any, overrun}, 3'b100);

    // R9 pop on empty
    step(0, 8'h00, 3'b000, 1, 0);
    chk(level == 0 && !err_any, "R9 pop empty ignored", level, 0);
    // R5 empty head zero
    chk(head_data == 0 && {head_brk, head_fe, head_pe} == 0, "R5 empty head zero", head_data, 0);

    // clean ordering R2
    for (int i = 0; i < 5; i++) step(1, 8'h10 + 8'(i), 3'b000, 0, 0);
    for (int i = 0; i < 5; i++) begin
      chk(head_data == 8'h10 + 8'(i), "R2 order", head_data, 8'h10 + i);
      step(0, 8'h00, 3'b000, 1, 0);
    end

    // error pattern R3 R4 R6
    step(1, 8'hA0, 3'b000, 0, 0);
    step(1, 8'hA1, 3'b010, 0, 0);
    step(1, 8'hA2, 3'b000, 0, 0);
    step(1, 8'hA3, 3'b101, 0, 0);
    step(1, 8'hA4, 3'b000, 0, 0);
    chk(err_any, "R6 summary set", err_any, 1);
    step(0, 8'h00, 3'b000, 1, 0);
    chk({head_brk, head_fe, head_pe} == 3'b010 && head_data == 8'hA1, "R4 next head flags",
        {head_brk, head_fe, head_pe}, 3'b010);
    step(0, 8'h00, 3'b000, 1, 0);
    chk({head_brk, head_fe, head_pe} == 3'b000, "R4 clean head after pop",
        {head_brk, head_fe, head_pe}, 0);
    chk(err_any, "R6 summary held by later entry", err_any, 1);
    step(0, 8'h00, 3'b000, 1, 0);
    chk({head_brk, head_fe, head_pe} == 3'b101, "R3 head brk+pe",
        {head_brk, head_fe, head_pe}, 3'b101);
    step(0, 8'h00, 3'b000, 1, 0);
    chk(!err_any && level == 1, "R6 summary clears with last error", err_any, 0);
    step(0, 8'h00, 3'b000, 1, 0);

    // R7 push+pop mid level
    step(1, 8'h01, 3'b100, 0, 0);
    step(1, 8'h02, 3'b000, 1, 0);
    chk(level == 1 && head_data == 8'h02 && !err_any, "R7 push+pop same cycle", level, 1);
    step(0, 8'h00, 3'b000, 1, 0);

    // fill to full, R8, R7 at full
    for (int i = 0; i < DEPTH; i++) step(1, 8'(i), (i == 10) ? 3'b001 : 3'b000, 0, 0);
    chk(full && level == DEPTH, "R1 full at depth", level, DEPTH);
    step(1, 8'hEE, 3'b111, 0, 0);
    chk(overrun && level == DEPTH, "R8 overrun pulse", overrun, 1);
    idle();
    chk(!overrun, "R8 pulse one cycle", overrun, 0);
    step(1, 8'hEF, 3'b000, 1, 0);
    chk(full && !overrun && head_data == 8'h01, "R7 push+pop at full", {full, overrun}, 2'b10);

    // R10 clear
    step(1, 8'h55, 3'b010, 1, 1);
    chk(empty && !err_any && !overrun, "R10 clear", {empty, err_any}, 2'b10);

    // random traffic with wrap-around
    for (int n = 0; n < 4000; n++) begin
      bit pu, po, cl;
      logic [2:0] f;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pu = (n % 600 < 300) ? (lfsr[2:0] != 0) : (lfsr[2:0] == 0);
      po = (n % 600 < 300) ? (lfsr[5:3] == 0) : (lfsr[5:3] != 0);
      cl = (lfsr[15:6] == 10'h3FF);
      f  = (lfsr[9:7] == 0) ? lfsr[12:10] : 3'b000;
      step(pu, lfsr[13:6], f, po, cl);
    end
    while (q.size() > 0) step(0, 8'h00, 3'b000, 1, 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule